// File: doc/BRIEF.md
# Block-Serviced Transmit/Receive FIFO Controller

This block buffers bytes between a register-access port and a serial shift engine. Software fills a transmit queue and empties a receive queue. It works in blocks of four words, and it is paced by two service request flags rather than by polling each word. A request means either that the transmit side has room for the next block or that a block of received words is waiting. Software acknowledges a request by writing 1 to that flag's bit in the status word. A flag that is still justified comes back one cycle later.

Software programs a transmit word count and a receive word count before it starts the engine. On entry to the running state the block copies both counts into remaining-word counters. These counters let the last, shorter block raise a request too. When the transfer runs in both directions, the engine returns one received word for every word it sends. Software must drain each of those words even when they carry no useful data. Returning the control bit to 0 puts the block in its idle state. In that state both queues are emptied and every flag and error bit is cleared.

Top module: `blk_svc_fifo`

## Requirements
- R1: After reset the block is idle. A status read returns 0, `reg_rdata` is 0 and `eng_tx_valid` is low.
- R2: While the block is running, a write to address 1 queues `reg_wdata[7:0]` for transmit. `eng_tx_valid` is high whenever the transmit queue is not empty. After each `eng_tx_pop`, `eng_tx_data` shows the oldest queued byte on the following cycle, in write order.
- R3: While the block is running, a read of address 2 removes the oldest received byte. `reg_rdata` shows that byte in bits [7:0], with the upper bits zero, on the cycle after the read.
- R4: A read of address 0 returns a status word in which every other bit is 0. The bits are:
  - bit 4: transmit queue not empty
  - bit 5: receive data available
  - bit 6: transmit queue full (16 words by default)
  - bit 8: output service request
  - bit 9: input service request
  - bit 10: overrun error
  - bit 11: underrun error
- R5: The output service request is set when transmit words are still owed (tx_remain not 0) and the free transmit entries are at least the smaller of 4 and tx_remain. The count written to address 4 is loaded into tx_remain when the block enters the running state. Each accepted transmit write decrements it.
- R6: The input service request is set when rx_remain is not 0 and the receive queue holds at least the smaller of 4 and rx_remain. The count written to address 5 is loaded into rx_remain when the block enters the running state. Each accepted receive read decrements it.
- R7: Writing 1 to status bit 8 or bit 9 clears that flag on the next cycle. Writing 0 leaves it set. If its condition still holds, the flag is set again on the cycle after that.
- R8: A transmit write to a full queue is dropped. The queue contents are unchanged and the overrun bit 10 is set and stays set while running.
- R9: A receive read from an empty queue returns 0 and sets the underrun bit 11, which stays set while running.
- R10: Writing 0 to bit 0 of address 3 makes the block idle. Both queues are emptied, all flags and error bits are cleared, and data reads and writes are ignored. Writing 1 to bit 0 makes the block run again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data, valid on the cycle after a read |
| eng_tx_valid | output | 1 | Transmit queue holds a word for the engine |
| eng_tx_pop | input | 1 | Engine takes the oldest transmit word |
| eng_tx_data | output | 8 | Word taken by the previous pop |
| eng_rx_push | input | 1 | Engine delivers a received word |
| eng_rx_data | input | 8 | Received word |

## Verification
The bench targets the final short block, where a design that compared only against a full block of four would never raise the last request and the transfer would stall. It acknowledges a flag while its condition still holds, to expose a flag that stays low after acknowledgement. It acknowledges a flag whose condition has gone away, to expose a flag that was built as a plain level and not as a held request. It overfills the transmit queue and reads the empty receive queue: a wrong design would either let the seventeenth byte reach the engine or return stale bytes, and could also lose the sticky error bit. It returns to idle with data still queued, which catches leftover words, flags or errors carried into the next transfer.

// File: rtl/bfs_pkg.sv
package bfs_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_STAT = 3'd0;
  localparam logic [ADDR_W-1:0] A_TXD  = 3'd1;
  localparam logic [ADDR_W-1:0] A_RXD  = 3'd2;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd3;
  localparam logic [ADDR_W-1:0] A_TXN  = 3'd4;
  localparam logic [ADDR_W-1:0] A_RXN  = 3'd5;

  localparam int B_TX_NE   = 4;
  localparam int B_RX_AV   = 5;
  localparam int B_TX_FULL = 6;
  localparam int B_OUT_SVC = 8;
  localparam int B_IN_SVC  = 9;
  localparam int B_OVR     = 10;
  localparam int B_UNR     = 11;

  typedef enum logic [1:0] {RK_NONE, RK_STAT, RK_RX} rd_kind_e;
endpackage

// File: rtl/bfs_fifo.sv
module bfs_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         clr,
  input  logic                         push,
  input  logic [DW-1:0]                din,
  input  logic                         pop,
  output logic [DW-1:0]                dout,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         full,
  output logic                         empty
);
  localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LVL_W = $clog2(DEPTH+1);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic          do_push, do_pop;

  assign full    = (count == LVL_W'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full && !clr;
  assign do_pop  = pop && !empty && !clr;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (do_pop) dout <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= bump(wptr);
      if (do_pop)  rptr <= bump(rptr);
      if (do_push && !do_pop)      count <= count + 1'b1;
      else if (do_pop && !do_push) count <= count - 1'b1;
    end
  end

  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (clr)
    (full && push && !pop) |=> (count == LVL_W'(DEPTH))); // R8
  AST_EMPTY_HOLDS: assert property (@(posedge clk) disable iff (clr)
    (empty && pop && !push) |=> (count == '0)); // R9
endmodule

// File: rtl/bfs_svc_flag.sv
module bfs_svc_flag #(
  parameter int LVL_W = 5,
  parameter int CNT_W = 16,
  parameter int BLK   = 4
) (
  input  logic             clk,
  input  logic             clr,
  input  logic [LVL_W-1:0] level,
  input  logic [CNT_W-1:0] remain,
  input  logic             ack,
  output logic             flag
);
  logic [CNT_W-1:0] need;
  logic             cond;

  always_comb begin
    need = (remain < CNT_W'(BLK)) ? remain : CNT_W'(BLK);
    cond = (remain != '0) && (32'(level) >= 32'(need));
  end

  always_ff @(posedge clk) begin
    if (clr)       flag <= 1'b0;
    else if (ack)  flag <= 1'b0;
    else if (cond) flag <= 1'b1;
  end

  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (clr)
    ack |=> !flag); // R7
  AST_RISE_NEEDS_WORK: assert property (@(posedge clk) disable iff (clr)
    $rose(flag) |-> ($past(remain) != '0)); // R5, R6
endmodule

// File: rtl/blk_svc_fifo.sv
module blk_svc_fifo
  import bfs_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  parameter int CNT_W = 16,
  parameter int REG_W = 32,
  parameter int BLK   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              eng_tx_valid,
  input  logic              eng_tx_pop,
  output logic [DW-1:0]     eng_tx_data,
  input  logic              eng_rx_push,
  input  logic [DW-1:0]     eng_rx_data
);
  localparam int LVL_W = $clog2(DEPTH+1);

  logic             run_q, clr;
  logic [CNT_W-1:0] tx_total, rx_total, tx_rem, rx_rem;
  logic             err_ovr, err_unr;
  logic [LVL_W-1:0] tx_cnt, rx_cnt, tx_free;
  logic             tx_full, tx_empty, rx_empty, rx_full_unused;
  logic [DW-1:0]    rx_dout;
  logic             wr_tx, rd_rx, tx_push, rx_pop;
  logic             out_flag, in_flag, ack_out, ack_in;
  logic [REG_W-1:0] stat_now, stat_q;
  rd_kind_e         rd_kind_q;

  assign clr      = rst || !run_q;
  assign wr_tx    = reg_wr && (reg_addr == A_TXD) && run_q;
  assign rd_rx    = reg_rd && (reg_addr == A_RXD) && run_q;
  assign tx_push  = wr_tx && !tx_full;
  assign rx_pop   = rd_rx && !rx_empty;
  assign tx_free  = LVL_W'(DEPTH) - tx_cnt;
  assign ack_out  = reg_wr && (reg_addr == A_STAT) && reg_wdata[B_OUT_SVC];
  assign ack_in   = reg_wr && (reg_addr == A_STAT) && reg_wdata[B_IN_SVC];
  assign eng_tx_valid = run_q && !tx_empty;

  bfs_fifo #(.DW(DW), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .clr(clr), .push(wr_tx), .din(reg_wdata[DW-1:0]),
    .pop(eng_tx_pop), .dout(eng_tx_data), .count(tx_cnt),
    .full(tx_full), .empty(tx_empty));

  bfs_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .clr(clr), .push(eng_rx_push), .din(eng_rx_data),
    .pop(rd_rx), .dout(rx_dout), .count(rx_cnt),
    .full(rx_full_unused), .empty(rx_empty));

  bfs_svc_flag #(.LVL_W(LVL_W), .CNT_W(CNT_W), .BLK(BLK)) u_out_svc (
    .clk(clk), .clr(clr), .level(tx_free), .remain(tx_rem),
    .ack(ack_out), .flag(out_flag));

  bfs_svc_flag #(.LVL_W(LVL_W), .CNT_W(CNT_W), .BLK(BLK)) u_in_svc (
    .clk(clk), .clr(clr), .level(rx_cnt), .remain(rx_rem),
    .ack(ack_in), .flag(in_flag));

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q    <= 1'b0;
      tx_total <= '0;
      rx_total <= '0;
      tx_rem   <= '0;
      rx_rem   <= '0;
      err_ovr  <= 1'b0;
      err_unr  <= 1'b0;
    end else begin
      if (reg_wr && (reg_addr == A_CTRL)) begin
        run_q <= reg_wdata[0];
        if (reg_wdata[0] && !run_q) begin
          tx_rem <= tx_total;
          rx_rem <= rx_total;
        end
      end
      if (reg_wr && (reg_addr == A_TXN)) tx_total <= reg_wdata[CNT_W-1:0];
      if (reg_wr && (reg_addr == A_RXN)) rx_total <= reg_wdata[CNT_W-1:0];
      if (tx_push && (tx_rem != '0)) tx_rem <= tx_rem - 1'b1;
      if (rx_pop && (rx_rem != '0))  rx_rem <= rx_rem - 1'b1;
      if (!run_q) begin
        err_ovr <= 1'b0;
        err_unr <= 1'b0;
      end else begin
        if (wr_tx && tx_full)  err_ovr <= 1'b1;
        if (rd_rx && rx_empty) err_unr <= 1'b1;
      end
    end
  end

  always_comb begin
    stat_now = '0;
    if (run_q) begin
      stat_now[B_TX_NE]   = !tx_empty;
      stat_now[B_RX_AV]   = !rx_empty;
      stat_now[B_TX_FULL] = tx_full;
      stat_now[B_OUT_SVC] = out_flag;
      stat_now[B_IN_SVC]  = in_flag;
      stat_now[B_OVR]     = err_ovr;
      stat_now[B_UNR]     = err_unr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_kind_q <= RK_NONE;
      stat_q    <= '0;
    end else if (reg_rd) begin
      case (reg_addr)
        A_STAT: begin
          rd_kind_q <= RK_STAT;
          stat_q    <= stat_now;
        end
        A_RXD:   rd_kind_q <= rx_pop ? RK_RX : RK_NONE;
        default: rd_kind_q <= RK_NONE;
      endcase
    end
  end

  always_comb begin
    case (rd_kind_q)
      RK_STAT: reg_rdata = stat_q;
      RK_RX:   reg_rdata = REG_W'(rx_dout);
      default: reg_rdata = '0;
    endcase
  end

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (run_q && $past(run_q) && $past(err_ovr)) |-> err_ovr); // R8
  AST_UNR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (run_q && $past(run_q) && $past(err_unr)) |-> err_unr); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !$past(run_q)) |-> (tx_cnt == '0 && rx_cnt == '0 && !out_flag && !in_flag)); // R10
endmodule

// File: tb/blk_svc_fifo_test.sv
module blk_svc_fifo_test;
  import bfs_pkg::*;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        eng_tx_valid, eng_tx_pop = 1'b0, eng_rx_push = 1'b0;
  logic [7:0]  eng_tx_data, eng_rx_data = '0;

  always #10 clk = ~clk;

  blk_svc_fifo uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_tx_valid(eng_tx_valid),
    .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data),
    .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data));

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [7:0] txq[$];
  logic [7:0] rxq[$];
  int tx_tot = 0, rx_tot = 0, tx_rem = 0, rx_rem = 0;
  bit running = 1'b0, ovr = 1'b0, unr = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int min_blk(input int r);
    return (r < 4) ? r : 4;
  endfunction

  function automatic logic [31:0] exp_stat();
    logic [31:0] s = '0;
    if (running) begin
      s[B_TX_NE]   = (txq.size() > 0);
      s[B_RX_AV]   = (rxq.size() > 0);
      s[B_TX_FULL] = (txq.size() == DEPTH);
      s[B_OUT_SVC] = (tx_rem > 0) && ((DEPTH - txq.size()) >= min_blk(tx_rem));
      s[B_IN_SVC]  = (rx_rem > 0) && (rxq.size() >= min_blk(rx_rem));
      s[B_OVR]     = ovr;
      s[B_UNR]     = unr;
    end
    return s;
  endfunction

  task automatic sw_wr(input logic [2:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic sw_rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    d = reg_rdata;
    reg_rd = 1'b0;
  endtask

  task automatic set_counts(input int t, input int r);
    sw_wr(A_TXN, t); sw_wr(A_RXN, r);
    tx_tot = t; rx_tot = r;
  endtask

  task automatic set_run(input bit b);
    sw_wr(A_CTRL, {31'b0, b});
    if (b && !running) begin tx_rem = tx_tot; rx_rem = rx_tot; end
    if (!b) begin txq.delete(); rxq.delete(); ovr = 1'b0; unr = 1'b0; end
    running = b;
  endtask

  task automatic tx_put(input logic [7:0] b);
    sw_wr(A_TXD, {24'b0, b});
    if (running) begin
      if (txq.size() < DEPTH) begin
        txq.push_back(b);
        if (tx_rem > 0) tx_rem--;
      end else ovr = 1'b1;
    end
  endtask

  task automatic rx_get();
    logic [31:0] d, e;
    string tag;
    sw_rd(A_RXD, d);
    e = '0; tag = "R3";
    if (running) begin
      if (rxq.size() > 0) begin
        e = {24'b0, rxq.pop_front()};
        if (rx_rem > 0) rx_rem--;
      end else begin
        unr = 1'b1; tag = "R9";
      end
    end else tag = "R10";
    chk(d == e, tag, d, e);
  endtask

  task automatic eng_loop();
    logic [7:0] got, e;
    eng_tx_pop = 1'b1;
    @(negedge clk);
    eng_tx_pop = 1'b0;
    got = eng_tx_data;
    e = txq.pop_front();
    chk(got == e, "R2", {24'b0, got}, {24'b0, e});
    eng_rx_data = got; eng_rx_push = 1'b1;
    @(negedge clk);
    eng_rx_push = 1'b0;
    if (rxq.size() < DEPTH) rxq.push_back(got);
  endtask

  task automatic check_flags(input string req);
    logic [31:0] d;
    sw_wr(A_STAT, 32'h300);
    @(negedge clk);
    @(negedge clk);
    sw_rd(A_STAT, d);
    chk(d == exp_stat(), req, d, exp_stat());
  endtask

  initial begin
    logic [31:0] d;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(reg_rdata == 0, "R1", reg_rdata, 0);
    chk(eng_tx_valid == 1'b0, "R1", {31'b0, eng_tx_valid}, 0);
    sw_rd(A_STAT, d);
    chk(d == 0, "R1", d, 0);

    // Directed transfer of 6 words, both directions
    set_counts(6, 6);
    set_run(1'b1);
    check_flags("R5");
    // R7: ack while condition holds -> low one cycle, then back
    sw_wr(A_STAT, 32'h100);
    sw_rd(A_STAT, d);
    chk(d[B_OUT_SVC] == 1'b0, "R7", {31'b0, d[B_OUT_SVC]}, 0);
    sw_rd(A_STAT, d);
    chk(d[B_OUT_SVC] == 1'b1, "R7", {31'b0, d[B_OUT_SVC]}, 1);
    for (int i = 0; i < 4; i++) tx_put(8'($urandom));
    check_flags("R5");
    chk(eng_tx_valid == 1'b1, "R2", {31'b0, eng_tx_valid}, 1);
    for (int i = 0; i < 4; i++) eng_loop();
    chk(eng_tx_valid == 1'b0, "R2", {31'b0, eng_tx_valid}, 0);
    check_flags("R6");
    for (int i = 0; i < 2; i++) tx_put(8'($urandom));
    check_flags("R5");
    for (int i = 0; i < 2; i++) eng_loop();
    check_flags("R4");
    for (int i = 0; i < 4; i++) rx_get();
    check_flags("R6");
    for (int i = 0; i < 2; i++) rx_get();
    check_flags("R6");

    // R7: a raised flag whose condition is gone stays until a 1 is written
    set_run(1'b0);
    set_counts(4, 0);
    set_run(1'b1);
    @(negedge clk); @(negedge clk);
    for (int i = 0; i < 4; i++) tx_put(8'($urandom));
    sw_wr(A_STAT, 32'h0);
    @(negedge clk);
    sw_rd(A_STAT, d);
    chk(d[B_OUT_SVC] == 1'b1, "R7", {31'b0, d[B_OUT_SVC]}, 1);
    sw_wr(A_STAT, 32'h100);
    @(negedge clk); @(negedge clk);
    sw_rd(A_STAT, d);
    chk(d[B_OUT_SVC] == 1'b0, "R7", {31'b0, d[B_OUT_SVC]}, 0);

    // R8 overrun on full transmit queue
    set_run(1'b0);
    set_counts(20, 0);
    set_run(1'b1);
    for (int i = 0; i < DEPTH; i++) tx_put(8'($urandom));
    check_flags("R8");
    tx_put(8'hEE);
    check_flags("R8");
    for (int i = 0; i < DEPTH; i++) eng_loop();
    chk(eng_tx_valid == 1'b0, "R8", {31'b0, eng_tx_valid}, 0);
    check_flags("R8");
    // R9 underrun on empty receive queue
    for (int i = 0; i < DEPTH; i++) rx_get();
    rx_get();
    check_flags("R9");

    // R10 idle state
    tx_put(8'h11);
    set_run(1'b0);
    check_flags("R10");
    tx_put(8'h5A);
    rx_get();
    set_counts(0, 0);
    set_run(1'b1);
    chk(eng_tx_valid == 1'b0, "R10", {31'b0, eng_tx_valid}, 0);
    check_flags("R10");

    // Random transfers
    for (int r = 0; r < 20; r++) begin
      int n;
      n = 1 + int'($urandom % 12);
      set_run(1'b0);
      set_counts(n, n);
      set_run(1'b1);
      check_flags("R5");
      for (int i = 0; i < n; i++) tx_put(8'($urandom));
      check_flags("R5");
      for (int i = 0; i < n; i++) eng_loop();
      check_flags("R6");
      for (int i = 0; i < n; i++) rx_get();
      check_flags("R4");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule